// File: doc/BRIEF.md
# Fixed-Sequence BCD Digit Generator

This block is a synchronous counter that plays a fixed cycle of seven decimal digits, 4, 1, 5, 7, 2, 4, 1, on a 4-bit BCD output bus. It advances one digit per rising clock edge while the count-enable input is high. After the last digit it returns to the first, and the cycle repeats without end.

The sequence repeats values and does not rise monotonically, so the output cannot serve as the state. A 3-bit binary step index is held in D-type flip-flops. The first step of the cycle is index 0 and the last is index 6. A Moore-style combinational decoder turns that index into the BCD digit. Because the digit depends only on the registered index, it changes only just after a clock edge.

A synchronous, active-high reset puts the index back to the first step. The one unused index code, 7, is never reached in normal use. If it does appear, the next clock edge moves the index to the first step, whatever the enable input is doing, so the block recovers by itself.

Top module: `bcd_seq_gen`

## Requirements
- R1: With `rst` high at a rising edge, the output after that edge is BCD 4 (`4'b0100`).
- R2: With `rst` low and `en` high, each rising edge moves the output to the next digit of the cycle 4, 1, 5, 7, 2, 4, 1.
- R3: When the output shows the last digit of the cycle (the second 1), the next enabled edge returns the output to 4, and the cycle repeats.
- R4: With `rst` low and `en` low, a rising edge leaves the output unchanged.
- R5: The output is always one of the BCD codes 1, 2, 4, 5 or 7, so bit 3 is always 0.
- R6: The output never changes between clock edges, even if `en` toggles.
- R7: A reset in the middle of the cycle returns the output to 4, even when `en` is low. The next enabled edge then gives 1, and the cycle continues from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; the output holds when low |
| digit | output | 4 | BCD code of the current digit |

## Verification
Digits 4 and 1 each appear twice in the cycle. A design that decoded the output from the previous digit instead of from a separate index would go from the second 1 to 5, or from the first 1 to 4. The bench therefore follows the full seven-step order over three periods, and it checks the wrap from the last step explicitly.

The bench holds `en` low for several edges and looks for a digit that creeps forward. It also toggles `en` between edges, which catches a design whose output depends on `en` combinationally.

A reset with `en` low, applied in the middle of the cycle, exposes a reset that is gated by the enable. Checking the digit that follows the reset exposes a restart at the wrong step.

// File: rtl/bcd_seq_gen.sv
module bcd_seq_gen #(
  parameter int STATE_W = 3,
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  output logic [DIGIT_W-1:0] digit
);

  localparam logic [STATE_W-1:0] FIRST = '0;
  localparam logic [STATE_W-1:0] LAST  = STATE_W'(6);

  logic [STATE_W-1:0] state;
  logic [STATE_W-1:0] state_nxt;

  always_comb begin
    state_nxt = state;
    if (state > LAST)
      state_nxt = FIRST;
    else if (en)
      state_nxt = (state == LAST) ? FIRST : state + STATE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) state <= FIRST;
    else     state <= state_nxt;
  end

  always_comb begin
    case (state)
      STATE_W'(0): digit = DIGIT_W'(4);
      STATE_W'(1): digit = DIGIT_W'(1);
      STATE_W'(2): digit = DIGIT_W'(5);
      STATE_W'(3): digit = DIGIT_W'(7);
      STATE_W'(4): digit = DIGIT_W'(2);
      STATE_W'(5): digit = DIGIT_W'(4);
      STATE_W'(6): digit = DIGIT_W'(1);
      default:     digit = DIGIT_W'(4);
    endcase
  end

endmodule

// File: rtl/bcd_seq_gen_chk.sv
module bcd_seq_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [3:0] digit,
  input logic [2:0] state
);

  // R1
  reset_to_four_chk: assert property (@(posedge clk) rst |=> digit == 4'd4);

  // R2
  four_to_one_chk: assert property (@(posedge clk) disable iff (rst)
    (en && digit == 4'd4) |=> digit == 4'd1);

  // R2
  five_to_seven_chk: assert property (@(posedge clk) disable iff (rst)
    (en && digit == 4'd5) |=> digit == 4'd7);

  // R2
  seven_to_two_chk: assert property (@(posedge clk) disable iff (rst)
    (en && digit == 4'd7) |=> digit == 4'd2);

  // R3
  wrap_to_first_chk: assert property (@(posedge clk) disable iff (rst)
    (en && state == 3'd6) |=> (state == 3'd0 && digit == 4'd4));

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && state != 3'd7) |=> $stable(digit));

  // R5
  valid_bcd_chk: assert property (@(posedge clk) disable iff (rst)
    (digit == 4'd1 || digit == 4'd2 || digit == 4'd4 || digit == 4'd5 || digit == 4'd7));

  // R5
  unused_state_recover_chk: assert property (@(posedge clk) disable iff (rst)
    state == 3'd7 |=> state == 3'd0);

endmodule

bind bcd_seq_gen bcd_seq_gen_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .digit(digit), .state(state)
);

// File: tb/test_bcd_seq_gen.sv
module test_bcd_seq_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] digit;

  int checks = 0;
  int errors = 0;
  int pos    = 0;
  bit done   = 1'b0;

  bcd_seq_gen i_bcd_seq_gen (.clk(clk), .rst(rst), .en(en), .digit(digit));

  always #5 clk = ~clk;

  function automatic logic [3:0] exp_digit(int p);
    case (p % 7)
      0: return 4'd4;
      1: return 4'd1;
      2: return 4'd5;
      3: return 4'd7;
      4: return 4'd2;
      5: return 4'd4;
      default: return 4'd1;
    endcase
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: digit=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1;
    step();
    pos = 0;
    check("R1", digit, 4'd4);
    check("R5", {3'b000, digit[3]}, 4'd0);
  endtask

  task automatic t_cycle();
    rst = 1'b0; en = 1'b1;
    for (int i = 0; i < 21; i++) begin
      step();
      pos = (pos + 1) % 7;
      if (pos == 0) check("R3", digit, 4'd4);
      else          check("R2", digit, exp_digit(pos));
      check("R5", {3'b000, digit[3]}, 4'd0);
    end
  endtask

  task automatic t_hold();
    en = 1'b1;
    for (int i = 0; i < 2; i++) begin
      step();
      pos = (pos + 1) % 7;
    end
    en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      check("R4", digit, exp_digit(pos));
    end
    en = 1'b1;
    step();
    pos = (pos + 1) % 7;
    check("R2", digit, exp_digit(pos));
  endtask

  task automatic t_between_edges();
    logic [3:0] held;
    held = digit;
    en = 1'b0; #1;
    check("R6", digit, held);
    en = 1'b1; #1;
    check("R6", digit, held);
    en = 1'b0; #1;
    check("R6", digit, held);
    en = 1'b1;
    step();
    pos = (pos + 1) % 7;
    check("R6", digit, exp_digit(pos));
  endtask

  task automatic t_mid_reset();
    en = 1'b1;
    while (pos != 3) begin
      step();
      pos = (pos + 1) % 7;
    end
    check("R7", digit, 4'd7);
    rst = 1'b1; en = 1'b0;
    step();
    pos = 0;
    check("R7", digit, 4'd4);
    rst = 1'b0; en = 1'b1;
    step();
    pos = 1;
    check("R7", digit, 4'd1);
    for (int i = 0; i < 6; i++) begin
      step();
      pos = (pos + 1) % 7;
      check("R7", digit, exp_digit(pos));
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: digit=%0d expected=run complete", digit);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_cycle();
    t_hold();
    t_between_edges();
    t_mid_reset();
    t_cycle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule